// File: doc/BRIEF.md
# Cartridge Bank-Switch Controller

This block maps a cartridge's program ROM and pattern (character) ROM into the address spaces of an 8-bit console's CPU and picture processor. The CPU selects banks by writing anywhere in the 0x8000–0xFFFF range. The data bus plays no part in the selection. The low byte of the write address carries the whole command: its upper nibble says which bank register to load, and its lower nibble is the bank number. Which command nibbles count as valid depends on whether the write address is below 0x9000 or at or above it.

The CPU side has two 16 KB windows. 0x8000–0xBFFF always shows the first 16 KB of program ROM. 0xC000–0xFFFF shows the selected 16 KB bank. On the picture side, the whole 8 KB pattern space 0x0000–0x1FFF shows the selected 8 KB bank of character ROM. Both ROM sizes are powers of two and are set by parameters. Bank numbers wrap to the installed size. The physical address outputs follow the current registers and the input addresses combinationally, so they are ready to drive ROM arrays placed outside the block.

Top module: `cart_bank_switch`

## Requirements
- R1: While reset is held, and after it is released until the first bank write, the upper CPU window maps to the last 16 KB bank (PRG_BANKS-1) and the pattern window maps to bank 0.
- R2: For CPU addresses 0x8000–0xBFFF, prg_rom_addr equals cpu_addr[13:0] with all upper bits zero, whatever bank is selected.
- R3: For CPU addresses 0xC000–0xFFFF, prg_rom_addr equals selected_prg_bank*16384 + cpu_addr[13:0].
- R4: chr_rom_addr equals selected_chr_bank*8192 + ppu_addr[12:0].
- R5: A bank write takes its command from cpu_addr[7:4] and its bank number from cpu_addr[3:0]. Address bits 11:8 have no effect.
- R6: A write at 0x9000–0xFFFF with command 0xD loads the program bank, and one with command 0xE loads the character bank.
- R7: A write at 0x8000–0x8FFF with command 0xB loads the program bank, and one with command 0x7 loads the character bank.
- R8: Any other command nibble in either range changes neither bank. This includes 0xD/0xE below 0x9000 and 0xB/0x7 at or above 0x9000.
- R9: A write below 0x8000 changes nothing, and neither does a cycle with cpu_wr low.
- R10: The loaded bank number is the nibble masked with the bank count minus one (PRG_BANKS-1 or CHR_BANKS-1).
- R11: A bank write takes effect at the clock edge that samples it. In the write cycle itself the outputs still show the old bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address, for both reads and bank writes |
| cpu_wr | input | 1 | CPU write strobe, active high |
| ppu_addr | input | 13 | Picture-processor pattern address |
| prg_rom_addr | output | PRG_ADDR_W (17) | Physical program-ROM address |
| chr_rom_addr | output | CHR_ADDR_W (16) | Physical character-ROM address |

## Verification
A wrong bank register shows in the upper bits of prg_rom_addr as soon as the CPU reads the 0xC000 window. It shows in the upper bits of chr_rom_addr on the very next cycle, because the pattern output is always live. A decode fault, such as accepting a command from the wrong address range, a code read from the wrong nibble, or an ignored write obeyed, moves a register one edge after the write and is visible in the following cycle. The bench therefore follows every bank write with reads that expose both registers, and compares both outputs against an independent model on every clock.

// File: rtl/bank_sw_pkg.sv
`timescale 1ns/1ps
package bank_sw_pkg;

  typedef logic [3:0] nib_t;

  // command nibbles, split by write-address range
  localparam nib_t CMD_PRG_UPPER = 4'hD;
  localparam nib_t CMD_CHR_UPPER = 4'hE;
  localparam nib_t CMD_PRG_LOWER = 4'hB;
  localparam nib_t CMD_CHR_LOWER = 4'h7;

  typedef struct packed {
    logic prg_ld;
    logic chr_ld;
    nib_t bank;
  } bank_cmd_t;

endpackage

// File: rtl/bsw_cmd_decode.sv
`timescale 1ns/1ps
module bsw_cmd_decode
  import bank_sw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [3:0] cpu_hi,   // cpu_addr[15:12]
  input  logic [7:0] cpu_lo,   // cpu_addr[7:0]
  input  logic      cpu_wr,
  output bank_cmd_t cmd
);

  logic in_rom;
  logic upper_rng;
  nib_t code;
  nib_t prg_code;
  nib_t chr_code;

  always_comb begin
    in_rom    = cpu_hi[3];
    upper_rng = cpu_hi[3] & (cpu_hi[2:0] != 3'd0);
    code      = cpu_lo[7:4];
    prg_code  = upper_rng ? CMD_PRG_UPPER : CMD_PRG_LOWER;
    chr_code  = upper_rng ? CMD_CHR_UPPER : CMD_CHR_LOWER;
    cmd.bank   = cpu_lo[3:0];
    cmd.prg_ld = cpu_wr & in_rom & (code == prg_code);
    cmd.chr_ld = cpu_wr & in_rom & (code == chr_code);
  end

  // R8
  load_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.prg_ld, cmd.chr_ld}));

  // R9
  no_load_outside_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_wr || !cpu_hi[3]) |-> (!cmd.prg_ld && !cmd.chr_ld));

endmodule

// File: rtl/bsw_bank_regs.sv
`timescale 1ns/1ps
module bsw_bank_regs
  import bank_sw_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  parameter int CHR_BANKS = 8,
  localparam int PW = $clog2(PRG_BANKS),
  localparam int CW = $clog2(CHR_BANKS)
)(
  input  logic          clk,
  input  logic          rst,
  input  bank_cmd_t     cmd,
  output logic [PW-1:0] prg_sel,
  output logic [CW-1:0] chr_sel
);

  localparam logic [PW-1:0] PRG_LAST = PW'(PRG_BANKS - 1);
  localparam logic [PW-1:0] PRG_MASK = PW'(PRG_BANKS - 1);
  localparam logic [CW-1:0] CHR_MASK = CW'(CHR_BANKS - 1);

  logic [PW-1:0] prg_next;
  logic [CW-1:0] chr_next;

  always_comb begin
    prg_next = PW'(cmd.bank) & PRG_MASK;
    chr_next = CW'(cmd.bank) & CHR_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_sel <= PRG_LAST;
      chr_sel <= '0;
    end else begin
      if (cmd.prg_ld) prg_sel <= prg_next;
      if (cmd.chr_ld) chr_sel <= chr_next;
    end
  end

  // R1
  reset_banks_chk: assert property (@(posedge clk)
    rst |=> (prg_sel == PRG_LAST && chr_sel == '0));

  // R8
  prg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd.prg_ld |=> $stable(prg_sel));

  // R8
  chr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd.chr_ld |=> $stable(chr_sel));

  // R10
  prg_load_value_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.prg_ld |=> (prg_sel == (PW'($past(cmd.bank)) & PRG_MASK)));

endmodule

// File: rtl/bsw_addr_compose.sv
`timescale 1ns/1ps
module bsw_addr_compose #(
  parameter int PW = 3,
  parameter int CW = 3
)(
  input  logic [PW-1:0]  prg_sel,
  input  logic [CW-1:0]  chr_sel,
  input  logic [14:0]    cpu_addr,
  input  logic [12:0]    ppu_addr,
  output logic [PW+13:0] prg_rom_addr,
  output logic [CW+12:0] chr_rom_addr
);

  always_comb begin
    prg_rom_addr = {(cpu_addr[14] ? prg_sel : {PW{1'b0}}), cpu_addr[13:0]};
    chr_rom_addr = {chr_sel, ppu_addr};
  end

endmodule

// File: rtl/cart_bank_switch.sv
`timescale 1ns/1ps
module cart_bank_switch
  import bank_sw_pkg::*;
#(
  parameter int PRG_BANKS = 8,   // 16 KB program banks, power of two, >= 2
  parameter int CHR_BANKS = 8,   // 8 KB pattern banks, power of two, >= 2
  localparam int PW = $clog2(PRG_BANKS),
  localparam int CW = $clog2(CHR_BANKS),
  localparam int PRG_ADDR_W = PW + 14,
  localparam int CHR_ADDR_W = CW + 13
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [15:0]           cpu_addr,
  input  logic                  cpu_wr,
  input  logic [12:0]           ppu_addr,
  output logic [PRG_ADDR_W-1:0] prg_rom_addr,
  output logic [CHR_ADDR_W-1:0] chr_rom_addr
);

  bank_cmd_t     cmd;
  logic [PW-1:0] prg_sel;
  logic [CW-1:0] chr_sel;

  bsw_cmd_decode u_decode (
    .clk    (clk),
    .rst    (rst),
    .cpu_hi (cpu_addr[15:12]),
    .cpu_lo (cpu_addr[7:0]),
    .cpu_wr (cpu_wr),
    .cmd    (cmd)
  );

  bsw_bank_regs #(
    .PRG_BANKS (PRG_BANKS),
    .CHR_BANKS (CHR_BANKS)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .prg_sel (prg_sel),
    .chr_sel (chr_sel)
  );

  bsw_addr_compose #(
    .PW (PW),
    .CW (CW)
  ) u_compose (
    .prg_sel      (prg_sel),
    .chr_sel      (chr_sel),
    .cpu_addr     (cpu_addr[14:0]),
    .ppu_addr     (ppu_addr),
    .prg_rom_addr (prg_rom_addr),
    .chr_rom_addr (chr_rom_addr)
  );

  // R2
  lower_window_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:14] == 2'b10) |-> (prg_rom_addr[PRG_ADDR_W-1:14] == '0));

  // R4
  chr_offset_chk: assert property (@(posedge clk) disable iff (rst)
    chr_rom_addr[12:0] == ppu_addr);

  // R11
  upper_window_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:14] == 2'b11 && !cmd.prg_ld) |=>
      (cpu_addr[15:14] != 2'b11 || prg_rom_addr[PRG_ADDR_W-1:14] == $past(prg_rom_addr[PRG_ADDR_W-1:14])));

endmodule

// File: tb/cart_bank_switch_tb.sv
`timescale 1ns/1ps
module cart_bank_switch_tb_top;

  localparam int PRG_BANKS = 8;
  localparam int CHR_BANKS = 8;
  localparam int PAW = $clog2(PRG_BANKS) + 14;
  localparam int CAW = $clog2(CHR_BANKS) + 13;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [15:0]    cpu_addr = 16'h0000;
  logic           cpu_wr = 1'b0;
  logic [12:0]    ppu_addr = 13'h0000;
  logic [PAW-1:0] prg_rom_addr;
  logic [CAW-1:0] chr_rom_addr;

  int checks = 0;
  int errors = 0;
  int m_prg = 0;
  int m_chr = 0;
  bit model_ok = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cart_bank_switch #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, actual, expected, $time);
    end
  endtask

  // behavioural reference: bank state updated at each rising edge
  always @(posedge clk) begin
    int code;
    int nib;
    model_ok = 1;
    if (rst) begin
      m_prg = PRG_BANKS - 1;
      m_chr = 0;
    end else if (cpu_wr && cpu_addr >= 16'h8000) begin
      code = (cpu_addr >> 4) & 15;
      nib  = cpu_addr & 15;
      if (cpu_addr >= 16'h9000) begin
        if (code == 13) m_prg = nib % PRG_BANKS;
        if (code == 14) m_chr = nib % CHR_BANKS;
      end else begin
        if (code == 11) m_prg = nib % PRG_BANKS;
        if (code == 7)  m_chr = nib % CHR_BANKS;
      end
    end
  end

  // per-cycle comparison, half a period after the edge
  always @(negedge clk) begin
    if (model_ok && !done) begin
      if (cpu_addr >= 16'hC000)
        check(rst ? "R1" : "R3", int'(prg_rom_addr), m_prg * 16384 + (cpu_addr & 16'h3FFF));
      else if (cpu_addr >= 16'h8000)
        check("R2", int'(prg_rom_addr), cpu_addr & 16'h3FFF);
      check(rst ? "R1" : "R4", int'(chr_rom_addr), m_chr * 8192 + ppu_addr);
    end
  end

  task automatic wr(input logic [15:0] a);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wr = 1'b1;
    @(posedge clk); #1;
    cpu_wr = 1'b0; cpu_addr = 16'h8000;
  endtask

  task automatic probe(input string req, input logic [15:0] a, input logic [12:0] p,
                       input int exp_prg, input int exp_chr);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wr = 1'b0; ppu_addr = p;
    @(negedge clk);
    check(req, int'(prg_rom_addr), exp_prg);
    check(req, int'(chr_rom_addr), exp_chr);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset mapping
    probe("R1", 16'hC123, 13'h0456, 7*16384 + 16'h0123, 16'h0456);
    // R2 lower window fixed
    probe("R2", 16'h8ABC, 13'h1000, 16'h0ABC, 16'h1000);
    // R6 upper-range commands
    wr(16'h90D3);
    probe("R6", 16'hC010, 13'h0000, 3*16384 + 16'h10, 0);
    wr(16'hF0E5);
    probe("R6", 16'hFFFF, 13'h1FFF, 3*16384 + 16'h3FFF, 5*8192 + 16'h1FFF);
    // R7 lower-range commands
    wr(16'h80B2);
    probe("R7", 16'hFFFF, 13'h0001, 2*16384 + 16'h3FFF, 5*8192 + 1);
    wr(16'h8072);
    probe("R7", 16'hC000, 13'h0000, 2*16384, 2*8192);
    // R5 bits 11:8 ignored, command/bank from low byte
    wr(16'hA3D1);
    probe("R5", 16'hC004, 13'h0004, 1*16384 + 4, 2*8192 + 4);
    // R8 cross-range and unknown codes
    wr(16'h80D6); wr(16'h90B6); wr(16'h9074); wr(16'h80E4);
    wr(16'hC0A5); wr(16'h80F5); wr(16'hB005);
    probe("R8", 16'hC100, 13'h0100, 1*16384 + 16'h100, 2*8192 + 16'h100);
    // R9 below 0x8000 and strobe low
    wr(16'h70D4); wr(16'h10E4);
    probe("R9", 16'hD0D4, 13'h0000, 1*16384 + 16'h10D4, 2*8192);
    probe("R9", 16'hC000, 13'h0000, 1*16384, 2*8192);
    // R10 wrap by mask
    wr(16'h90DF);
    wr(16'h90E9);
    probe("R10", 16'hC000, 13'h0000, 7*16384, 1*8192);
    // R11 old bank visible during the write cycle, new one after
    @(posedge clk); #1;
    cpu_addr = 16'hD0D2; cpu_wr = 1'b1; ppu_addr = 13'h0;
    @(negedge clk);
    check("R11", int'(prg_rom_addr), 7*16384 + 16'h10D2);
    @(posedge clk); #1;
    cpu_wr = 1'b0;
    @(negedge clk);
    check("R11", int'(prg_rom_addr), 2*16384 + 16'h10D2);
    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      cpu_addr = 16'($urandom);
      if (($urandom % 3) == 0) cpu_addr[7:4] = ($urandom % 2) ? 4'hD : 4'hE;
      else if (($urandom % 3) == 0) cpu_addr[7:4] = ($urandom % 2) ? 4'hB : 4'h7;
      if (($urandom % 2) == 0) cpu_addr[15] = 1'b1;
      cpu_wr   = ($urandom % 2) == 0;
      ppu_addr = 13'($urandom);
      rst      = ($urandom % 97) == 0;
    end
    @(posedge clk); #1;
    rst = 1'b0; cpu_wr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule